// File: doc/BRIEF.md
# Eight-Channel Interrupt Status Aggregator

This block collects the interrupt requests of eight serial channels, plus a few device-wide events, into one 32-bit read-only status word. A host interrupt handler reads that word in a single access. From it the handler learns which channels need service and, for each of those channels, the most urgent cause.

The low byte is a summary vector with one bit per channel. The upper 24 bits hold a 3-bit cause code for each channel. Device-wide events (timer, general-purpose I/O, and a wake-up raised when the device leaves a state in which every channel was asleep) have no field of their own. They are reported in channel 0's code and its summary bit.

The wake-up event is held in the block. It is cleared when the host reads the status word with the summary byte lane enabled.

Top module: `irq_gather`

## Requirements
- R1: Summary bit n (bit n of the word) is 1 exactly when channel n has any pending line-status, receive, transmit or modem request; bit 0 is also 1 while any device-wide event is pending.
- R2: Channel n's 3-bit code occupies word bits [8+3n+2 : 8+3n] (channel 0 at [10:8], channel 7 at [31:29]); a code of 0 means nothing is pending on that channel.
- R3: Within a channel the code is priority-encoded, highest first: line status = 6, receive = 4, transmit = 2, modem status = 1.
- R4: In channel 0's code, device-wide events override local sources, highest first: wake-up = 7, timer = 5, general-purpose I/O = 3.
- R5: The wake-up event becomes pending on the clock edge at which all eight sleep inputs, having been all 1 at the previous edge, are no longer all 1. A sleep exit that did not start with all eight channels asleep raises no wake-up.
- R6: A read at address 0x80 with the low byte lane enabled clears a pending wake-up. A read with the low lane disabled, or a read at any other address, leaves it pending.
- R7: If a new wake-up and a clearing read fall on the same edge, the wake-up stays pending.
- R8: After reset the read data is zero, no wake-up is pending, and a read with no request inputs active returns zero.
- R9: Read data is registered. One edge after a read strobe it shows the status word when the address is 0x80 and zero for any other address, and it holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_line_req | input | 8 | Per-channel line-status request |
| ch_rx_req | input | 8 | Per-channel receive request |
| ch_tx_req | input | 8 | Per-channel transmit request |
| ch_modem_req | input | 8 | Per-channel modem-status request |
| ch_sleep | input | 8 | Per-channel sleep state |
| tmr_req | input | 1 | Device timer event pending |
| gpio_req | input | 1 | Device general-purpose I/O event pending |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| rd_low_lane | input | 1 | Read includes the summary byte lane |
| rd_data | output | 32 | Registered read data |

## Verification
A sleep exit that raises the wake-up event and a host read that clears it can occur on the same clock edge. The bench first leaves a wake-up pending. It then puts all eight channels back to sleep, and in one cycle releases sleep and issues a clearing read. The check passes only if the same value is returned on that read and on the next one, and the event disappears only after a second clearing read.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;
  localparam int NUM_CH = 8;
  localparam int CODE_W = 3;
  localparam int SUM_W  = NUM_CH;
  localparam int WORD_W = SUM_W + NUM_CH * CODE_W;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_NONE  = 3'd0;
  localparam code_t CODE_MODEM = 3'd1;
  localparam code_t CODE_TX    = 3'd2;
  localparam code_t CODE_GPIO  = 3'd3;
  localparam code_t CODE_RX    = 3'd4;
  localparam code_t CODE_TMR   = 3'd5;
  localparam code_t CODE_LINE  = 3'd6;
  localparam code_t CODE_WAKE  = 3'd7;
endpackage

// File: rtl/irq_chan_enc.sv
module irq_chan_enc
  import irq_gather_pkg::*;
(
  input  logic  line_req,
  input  logic  rx_req,
  input  logic  tx_req,
  input  logic  modem_req,
  output code_t code,
  output logic  pend
);
  always_comb begin
    if (line_req)       code = CODE_LINE;
    else if (rx_req)    code = CODE_RX;
    else if (tx_req)    code = CODE_TX;
    else if (modem_req) code = CODE_MODEM;
    else                code = CODE_NONE;
  end

  assign pend = line_req | rx_req | tx_req | modem_req;
endmodule

// File: rtl/irq_global_merge.sv
module irq_global_merge
  import irq_gather_pkg::*;
(
  input  code_t local_code,
  input  logic  local_pend,
  input  logic  wake_pend,
  input  logic  tmr_req,
  input  logic  gpio_req,
  output code_t code,
  output logic  pend
);
  always_comb begin
    if (wake_pend)     code = CODE_WAKE;
    else if (tmr_req)  code = CODE_TMR;
    else if (gpio_req) code = CODE_GPIO;
    else               code = local_code;
  end

  assign pend = local_pend | wake_pend | tmr_req | gpio_req;
endmodule

// File: rtl/irq_wake_det.sv
module irq_wake_det
  import irq_gather_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_sleep,
  input  logic              clr_req,
  output logic              wake_pend
);
  logic all_now;
  logic asleep_q, asleep_d;
  logic wake_q, wake_d;
  logic wake_set;

  assign all_now  = &ch_sleep;
  assign wake_set = asleep_q & ~all_now;

  always_comb begin
    asleep_d = all_now;
    wake_d   = wake_q;
    if (clr_req)  wake_d = 1'b0;
    if (wake_set) wake_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asleep_q <= 1'b0;
      wake_q   <= 1'b0;
    end else begin
      asleep_q <= asleep_d;
      wake_q   <= wake_d;
    end
  end

  assign wake_pend = wake_q;

  assert_wake_on_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && !all_now) |=> wake_q);
  assert_no_spurious_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_q && !(asleep_q && !all_now)) |=> !wake_q);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_q && clr_req && !(asleep_q && !all_now)) |=> !wake_q);
  assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep_q && !all_now && clr_req) |=> wake_q);
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irq_gather_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] ch_line_req,
  input  logic [NUM_CH-1:0] ch_rx_req,
  input  logic [NUM_CH-1:0] ch_tx_req,
  input  logic [NUM_CH-1:0] ch_modem_req,
  input  logic [NUM_CH-1:0] ch_sleep,
  input  logic              tmr_req,
  input  logic              gpio_req,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_low_lane,
  output logic [WORD_W-1:0] rd_data
);
  code_t             loc_code [NUM_CH];
  logic [NUM_CH-1:0] loc_pend;
  code_t             ch_code  [NUM_CH];
  logic [NUM_CH-1:0] ch_pend;
  logic [WORD_W-1:0] status;
  logic              wake_pend;
  logic              hit;
  logic              clr_req;
  logic [WORD_W-1:0] rd_d, rd_q;

  assign hit     = rd_en && (rd_addr == BASE_ADDR);
  assign clr_req = hit && rd_low_lane;

  irq_wake_det u_wake (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_sleep  (ch_sleep),
    .clr_req   (clr_req),
    .wake_pend (wake_pend)
  );

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    irq_chan_enc u_enc (
      .line_req  (ch_line_req[n]),
      .rx_req    (ch_rx_req[n]),
      .tx_req    (ch_tx_req[n]),
      .modem_req (ch_modem_req[n]),
      .code      (loc_code[n]),
      .pend      (loc_pend[n])
    );
    if (n == 0) begin : g_global
      irq_global_merge u_merge (
        .local_code (loc_code[n]),
        .local_pend (loc_pend[n]),
        .wake_pend  (wake_pend),
        .tmr_req    (tmr_req),
        .gpio_req   (gpio_req),
        .code       (ch_code[n]),
        .pend       (ch_pend[n])
      );
    end else begin : g_local
      assign ch_code[n] = loc_code[n];
      assign ch_pend[n] = loc_pend[n];

      assert_line_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ch_line_req[n] |-> status[SUM_W + n*CODE_W +: CODE_W] == CODE_LINE);
    end

    assert_sum_code_agree_R1: assert property (@(posedge clk) disable iff (!rst_n)
      status[n] == (status[SUM_W + n*CODE_W +: CODE_W] != CODE_NONE));
  end

  always_comb begin
    status = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      status[n] = ch_pend[n];
      status[SUM_W + n*CODE_W +: CODE_W] = ch_code[n];
    end
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = hit ? status : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;

  assert_wake_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pend |-> (status[SUM_W +: CODE_W] == CODE_WAKE) && status[0]);
  assert_miss_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> rd_data == '0);
  assert_hold_between_reads_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: tb/irq_gather_tb.sv
`timescale 1ns/1ps
module irq_gather_tb;
  localparam int NV = 10;
  localparam time TCLK = 20ns;

  // {line, rx, tx, modem, tmr, gpio, expected word}
  localparam logic [65:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 32'h0000_0000},
    {8'h00, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 32'h0000_0201},
    {8'h00, 8'h00, 8'h00, 8'h80, 1'b0, 1'b0, 32'h2000_0080},
    {8'h08, 8'h08, 8'h08, 8'h00, 1'b0, 1'b0, 32'h000C_0008},
    {8'h00, 8'h02, 8'h02, 8'h02, 1'b0, 1'b0, 32'h0000_2002},
    {8'h01, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0, 32'h0000_0501},
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1, 32'h0000_0301},
    {8'h00, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 32'h0000_0501},
    {8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0, 1'b0, 32'hDB6D_B6FF},
    {8'h00, 8'h00, 8'h04, 8'h20, 1'b0, 1'b0, 32'h0080_8024}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  ch_line_req, ch_rx_req, ch_tx_req, ch_modem_req, ch_sleep;
  logic        tmr_req, gpio_req, rd_en, rd_low_lane;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic [31:0] got;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(TCLK/2) clk = ~clk;

  irq_gather u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_line_req  (ch_line_req),
    .ch_rx_req    (ch_rx_req),
    .ch_tx_req    (ch_tx_req),
    .ch_modem_req (ch_modem_req),
    .ch_sleep     (ch_sleep),
    .tmr_req      (tmr_req),
    .gpio_req     (gpio_req),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_low_lane  (rd_low_lane),
    .rd_data      (rd_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [7:0] addr, input logic low, output logic [31:0] data);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = addr; rd_low_lane = low;
    @(negedge clk);
    rd_en = 1'b0;
    data = rd_data;
  endtask

  task automatic sleep_cycle(input logic [7:0] pattern);
    @(negedge clk) ch_sleep = pattern;
    @(negedge clk) ch_sleep = pattern;
    @(negedge clk) ch_sleep = 8'h00;
  endtask

  initial begin
    #(TCLK * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {ch_line_req, ch_rx_req, ch_tx_req, ch_modem_req, ch_sleep} = '0;
    {tmr_req, gpio_req, rd_en, rd_low_lane} = '0;
    rd_addr = 8'h00;
    repeat (3) @(negedge clk);
    check("R8 reset data", rd_data, 32'h0);
    rst_n = 1'b1;
    do_read(8'h80, 1'b1, got);
    check("R8 idle read after reset", got, 32'h0);

    // table-driven sweep (R1 R2 R3 R4)
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {ch_line_req, ch_rx_req, ch_tx_req, ch_modem_req, tmr_req, gpio_req} = VEC[i][65:32];
      do_read(8'h80, 1'b1, got);
      check($sformatf("R1/R2/R3/R4 vector %0d", i), got, VEC[i][31:0]);
    end

    // R9: other address reads zero, data holds between reads
    do_read(8'h84, 1'b1, got);
    check("R9 miss address", got, 32'h0);
    @(negedge clk) {ch_line_req, ch_rx_req, ch_tx_req, ch_modem_req, tmr_req, gpio_req} = '0;
    repeat (2) @(negedge clk);
    check("R9 hold between reads", rd_data, 32'h0);

    // R5: partial sleep gives no wake-up
    sleep_cycle(8'h7F);
    do_read(8'h80, 1'b1, got);
    check("R5 partial sleep no wake", got, 32'h0);

    // R5: full sleep exit raises wake-up; R6 reads without clearing
    sleep_cycle(8'hFF);
    do_read(8'h80, 1'b0, got);
    check("R5 wake after full sleep", got, 32'h0000_0701);
    @(negedge clk) tmr_req = 1'b1;
    do_read(8'h80, 1'b0, got);
    check("R4 wake beats timer", got, 32'h0000_0701);
    do_read(8'h81, 1'b1, got);
    check("R6 other address read", got, 32'h0);
    do_read(8'h80, 1'b1, got);
    check("R6 clearing read returns wake", got, 32'h0000_0701);
    do_read(8'h80, 1'b1, got);
    check("R6 wake cleared timer shows", got, 32'h0000_0501);
    @(negedge clk) tmr_req = 1'b0;

    // R7: new wake-up and clearing read on same edge
    sleep_cycle(8'hFF);
    @(negedge clk) ch_sleep = 8'hFF;
    @(negedge clk) ch_sleep = 8'hFF;
    @(negedge clk);
    ch_sleep = 8'h00; rd_en = 1'b1; rd_addr = 8'h80; rd_low_lane = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    check("R7 collision read data", rd_data, 32'h0000_0701);
    do_read(8'h80, 1'b1, got);
    check("R7 wake survived collision", got, 32'h0000_0701);
    do_read(8'h80, 1'b1, got);
    check("R7 cleared afterwards", got, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule